// File: doc/BRIEF.md
# Opcode-Driven Integer ALU

This block is a purely combinational arithmetic-logic unit for two operand words (32 bits by default). A 4-bit function code picks one of fourteen operations: addition, subtraction, signed comparison, set-if-less, bitwise and, or, xor and invert, four shift kinds, a pass-through of the second operand, and an idle code. Beyond the result word it reports a carry-out, a signed overflow flag and three magnitude flags: greater, equal and less.

One ripple adder serves addition, subtraction and both signed comparisons. For subtraction-like codes the second operand is inverted bit by bit and the same control bit enters as the carry-in, so the adder computes A + ~B + 1. The comparison flags come from that difference and its overflow bit. Shifts move operand A by the count held in the low bits of operand B. A datapath wraps registers around the block and presents operands and a code each cycle.

Top module: `alu_core`

## Requirements
- R1: Function code 4'h0 (idle) and the unused codes 4'hE and 4'hF give a result of zero, with carry-out, overflow and all three magnitude flags low.
- R2: Code 4'h1 gives result = A + B modulo 2^32, and carry-out is the bit that leaves the top of that sum.
- R3: Code 4'h2 gives result = A - B modulo 2^32, and carry-out is the carry leaving the top bit of A + ~B + 1, so it is 1 when A >= B as unsigned values.
- R4: For codes 4'h1 and 4'h2, overflow is 1 exactly when the signed result does not fit in 32 bits, that is, when the carry into the top bit differs from the carry out of it.
- R5: Code 4'h3 gives a result of zero and raises exactly one of greater, equal and less, chosen by a signed comparison of A with B.
- R6: For every code other than 4'h3 the greater, equal and less flags are all low.
- R7: Code 4'h4 gives 32'h1 when A < B as signed values and 32'h0 otherwise.
- R8: Code 4'h5 gives A & B, 4'h6 gives A | B, 4'h8 gives A ^ B, and 4'h7 gives ~A (B ignored).
- R9: Codes 4'h9 and 4'hB both shift A left by B[4:0] places with zero fill. Bits B[31:5] have no effect on any shift.
- R10: Code 4'hA shifts A right by B[4:0] places and fills with zeros.
- R11: Code 4'hC shifts A right by B[4:0] places and fills with copies of A[31].
- R12: Code 4'hD passes B through unchanged.
- R13: Carry-out and overflow are 0 for every code other than 4'h1 and 4'h2, even when the shared adder is busy for a comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Function code selecting the operation |
| opnd_a | input | 32 | First operand; the value that shifts move |
| opnd_b | input | 32 | Second operand; its low 5 bits set the shift count |
| result | output | 32 | Selected result word |
| carry_out | output | 1 | Adder carry-out, add and subtract only |
| overflow | output | 1 | Signed overflow, add and subtract only |
| flag_gt | output | 1 | A greater than B (signed), compare only |
| flag_eq | output | 1 | A equal to B, compare only |
| flag_lt | output | 1 | A less than B (signed), compare only |

## Verification
The hardest case to reach is a signed comparison whose internal difference overflows. There the sign bit of A - B gives the wrong answer, and only the overflow correction decides between greater and less. The stimulus forces this with operand pairs at opposite ends of the signed range, such as 32'h7FFFFFFF against 32'h80000000 and the reverse. It also uses carry-heavy pairs under the comparison code, to show that the adder's carry and overflow do not reach the outputs. Shift tests put set bits in B[31:5] to show those bits are ignored.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    FN_IDLE = 4'h0,
    FN_ADD  = 4'h1,
    FN_SUB  = 4'h2,
    FN_CMP  = 4'h3,
    FN_SLT  = 4'h4,
    FN_AND  = 4'h5,
    FN_OR   = 4'h6,
    FN_INV  = 4'h7,
    FN_XOR  = 4'h8,
    FN_SHL  = 4'h9,
    FN_SHR  = 4'hA,
    FN_ASL  = 4'hB,
    FN_ASR  = 4'hC,
    FN_MOVB = 4'hD
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT      = 2'd0,
    SH_RIGHT_LOG = 2'd1,
    SH_RIGHT_ARI = 2'd2
  } shift_kind_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         do_sub,
  output logic [W-1:0] sum,
  output logic         cy_out,
  output logic         ovf
);

  logic [W:0]   cy;
  logic [W-1:0] b_eff;

  assign cy[0] = do_sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i]  = in_b[i] ^ do_sub;
    assign sum[i]    = in_a[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (in_a[i] & b_eff[i]) | (in_a[i] & cy[i]) | (b_eff[i] & cy[i]);
  end

  assign cy_out = cy[W];
  assign ovf    = cy[W] ^ cy[W-1];

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amount,
  input  shift_kind_e    kind,
  output logic [W-1:0]   dout
);

  logic [W-1:0] stage [0:SHW];
  logic         fill;

  assign fill     = (kind == SH_RIGHT_ARI) ? din[W-1] : 1'b0;
  assign stage[0] = din;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [W-1:0] fill_mask;
    assign fill_mask = {W{fill}} << (W - STEP);
    always_comb begin
      if (!amount[k]) begin
        stage[k+1] = stage[k];
      end else if (kind == SH_LEFT) begin
        stage[k+1] = stage[k] << STEP;
      end else begin
        stage[k+1] = (stage[k] >> STEP) | fill_mask;
      end
    end
  end

  assign dout = stage[SHW];

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] diff,
  input  logic         diff_ovf,
  output logic         is_gt,
  output logic         is_eq,
  output logic         is_lt
);

  always_comb begin
    is_eq = (diff == '0);
    is_lt = diff[W-1] ^ diff_ovf;
    is_gt = !is_eq && !is_lt;
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_code,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow,
  output logic             flag_gt,
  output logic             flag_eq,
  output logic             flag_lt
);

  localparam int SHW = $clog2(WIDTH);

  logic             sub_mode;
  logic             arith_op;
  logic             cmp_op;
  logic [WIDTH-1:0] add_sum;
  logic             add_cy;
  logic             add_ovf;
  logic [WIDTH-1:0] sh_out;
  shift_kind_e      sh_kind;
  logic             c_gt, c_eq, c_lt;

  always_comb begin
    sub_mode = (op_code == FN_SUB) || (op_code == FN_CMP) || (op_code == FN_SLT);
    arith_op = (op_code == FN_ADD) || (op_code == FN_SUB);
    cmp_op   = (op_code == FN_CMP);
    case (op_code)
      FN_SHR:  sh_kind = SH_RIGHT_LOG;
      FN_ASR:  sh_kind = SH_RIGHT_ARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_addsub #(.W(WIDTH)) u_addsub (
    .in_a   (opnd_a),
    .in_b   (opnd_b),
    .do_sub (sub_mode),
    .sum    (add_sum),
    .cy_out (add_cy),
    .ovf    (add_ovf)
  );

  alu_shifter #(.W(WIDTH), .SHW(SHW)) u_shifter (
    .din    (opnd_a),
    .amount (opnd_b[SHW-1:0]),
    .kind   (sh_kind),
    .dout   (sh_out)
  );

  alu_compare #(.W(WIDTH)) u_compare (
    .diff     (add_sum),
    .diff_ovf (add_ovf),
    .is_gt    (c_gt),
    .is_eq    (c_eq),
    .is_lt    (c_lt)
  );

  always_comb begin
    result = '0;
    case (op_code)
      FN_ADD, FN_SUB:          result = add_sum;
      FN_SLT:                  result = {{(WIDTH-1){1'b0}}, c_lt};
      FN_AND:                  result = opnd_a & opnd_b;
      FN_OR:                   result = opnd_a | opnd_b;
      FN_INV:                  result = ~opnd_a;
      FN_XOR:                  result = opnd_a ^ opnd_b;
      FN_SHL, FN_SHR,
      FN_ASL, FN_ASR:          result = sh_out;
      FN_MOVB:                 result = opnd_b;
      default:                 result = '0;
    endcase
    carry_out = arith_op ? add_cy  : 1'b0;
    overflow  = arith_op ? add_ovf : 1'b0;
    flag_gt   = cmp_op & c_gt;
    flag_eq   = cmp_op & c_eq;
    flag_lt   = cmp_op & c_lt;
  end

  always_comb begin
    if (op_code == FN_CMP) begin
      AST_CMP_ONEHOT: assert ($countones({flag_gt, flag_eq, flag_lt}) == 1) else $error("compare flags not one-hot"); // R5
      AST_CMP_EQ_MATCH: assert (flag_eq == (opnd_a == opnd_b)) else $error("equal flag mismatch"); // R5
      AST_CMP_ZERO_RES: assert (result == '0) else $error("compare result nonzero"); // R5
    end else begin
      AST_FLAGS_QUIET: assert (!flag_gt && !flag_eq && !flag_lt) else $error("flags raised outside compare"); // R6
    end
    if (!(op_code == FN_ADD || op_code == FN_SUB)) begin
      AST_NO_CARRY_OVF: assert (!carry_out && !overflow) else $error("carry/overflow outside add/sub"); // R13
    end
    if (op_code == FN_SLT) begin
      AST_SLT_SIGNED: assert (result == (($signed(opnd_a) < $signed(opnd_b)) ? 1 : 0)) else $error("slt wrong"); // R7
    end
    if (op_code == FN_ADD) begin
      AST_ADD_OVF_SIGNS: assert (overflow == ((opnd_a[WIDTH-1] == opnd_b[WIDTH-1]) && (result[WIDTH-1] != opnd_a[WIDTH-1]))) else $error("add overflow wrong"); // R4
    end
    if (op_code == FN_MOVB) begin
      AST_MOVE_PASS: assert (result == opnd_b) else $error("move wrong"); // R12
    end
  end

endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;
  logic        carry_out, overflow, flag_gt, flag_eq, flag_lt;

  int checks = 0;
  int errors = 0;

  alu_core u_alu_core (
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (result),
    .carry_out (carry_out),
    .overflow  (overflow),
    .flag_gt   (flag_gt),
    .flag_eq   (flag_eq),
    .flag_lt   (flag_lt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // expected-value model written from the requirements
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] r, output logic c, output logic v,
                       output logic g, output logic e, output logic l);
    logic [32:0] wide;
    logic [4:0]  n;
    n = b[4:0];
    r = 32'h0; c = 1'b0; v = 1'b0; g = 1'b0; e = 1'b0; l = 1'b0;
    case (op)
      4'h1: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[31:0]; c = wide[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'h2: begin
        wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = wide[31:0]; c = wide[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'h3: begin
        g = $signed(a) > $signed(b);
        e = a == b;
        l = $signed(a) < $signed(b);
      end
      4'h4: r = ($signed(a) < $signed(b)) ? 32'h1 : 32'h0;
      4'h5: r = a & b;
      4'h6: r = a | b;
      4'h7: r = ~a;
      4'h8: r = a ^ b;
      4'h9, 4'hB: r = a << n;
      4'hA: r = a >> n;
      4'hC: r = $unsigned($signed(a) >>> n);
      4'hD: r = b;
      default: r = 32'h0;
    endcase
  endtask

  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic ec, ev, eg, ee, el;
    @(posedge clk);
    op_code = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    model(op, a, b, er, ec, ev, eg, ee, el);
    checks++;
    if (result !== er || carry_out !== ec || overflow !== ev ||
        flag_gt !== eg || flag_eq !== ee || flag_lt !== el) begin
      errors++;
      $display("FAIL %s op=%h a=%h b=%h: got r=%h c=%b v=%b gel=%b%b%b exp r=%h c=%b v=%b gel=%b%b%b",
               req, op, a, b, result, carry_out, overflow, flag_gt, flag_eq, flag_lt,
               er, ec, ev, eg, ee, el);
    end
  endtask

  task automatic t_idle_unused;
    run("R1", 4'h0, 32'hFFFF_FFFF, 32'h0000_0001);
    run("R1", 4'hE, 32'h1234_5678, 32'h8765_4321);
    run("R1", 4'hF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_add;
    run("R2", 4'h1, 32'd5, 32'd7);
    run("R2", 4'h1, 32'hFFFF_FFFF, 32'h0000_0001);
    run("R4", 4'h1, 32'h7FFF_FFFF, 32'h0000_0001);
    run("R4", 4'h1, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_sub;
    run("R3", 4'h2, 32'd5, 32'd3);
    run("R3", 4'h2, 32'd0, 32'd1);
    run("R3", 4'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    run("R4", 4'h2, 32'h8000_0000, 32'h0000_0001);
    run("R4", 4'h2, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
  endtask

  task automatic t_compare;
    run("R5", 4'h3, 32'd10, 32'd3);
    run("R5", 4'h3, 32'd3, 32'd10);
    run("R5", 4'h3, 32'hCAFE_0001, 32'hCAFE_0001);
    run("R5", 4'h3, 32'h7FFF_FFFF, 32'h8000_0000);
    run("R5", 4'h3, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R5", 4'h3, 32'hFFFF_FFFF, 32'h0000_0001);
  endtask

  task automatic t_slt;
    run("R7", 4'h4, 32'hFFFF_FFFE, 32'h0000_0001);
    run("R7", 4'h4, 32'h0000_0001, 32'hFFFF_FFFE);
    run("R7", 4'h4, 32'h8000_0000, 32'h7FFF_FFFF);
    run("R7", 4'h4, 32'h0000_0042, 32'h0000_0042);
  endtask

  task automatic t_logic;
    run("R8", 4'h5, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    run("R8", 4'h6, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    run("R8", 4'h8, 32'hF0F0_FF00, 32'h3C3C_0FF0);
    run("R8", 4'h7, 32'h0F0F_1234, 32'hFFFF_FFFF);
  endtask

  task automatic t_shifts;
    run("R9", 4'h9, 32'h8000_0001, 32'd1);
    run("R9", 4'hB, 32'h8000_0001, 32'd1);
    run("R9", 4'h9, 32'h0000_00FF, 32'hFFFF_FFE4);
    run("R9", 4'hB, 32'h1234_5678, 32'd31);
    run("R10", 4'hA, 32'h8000_0000, 32'd31);
    run("R10", 4'hA, 32'hF000_000F, 32'h0000_0124);
    run("R10", 4'hA, 32'hA5A5_A5A5, 32'h0000_0020);
    run("R11", 4'hC, 32'h8000_0000, 32'd31);
    run("R11", 4'hC, 32'hF000_000F, 32'd4);
    run("R11", 4'hC, 32'h7000_0000, 32'hFFFF_FFE8);
  endtask

  task automatic t_move;
    run("R12", 4'hD, 32'h1111_1111, 32'hBEEF_CAFE);
    run("R12", 4'hD, 32'hFFFF_FFFF, 32'h0000_0000);
  endtask

  task automatic t_quiet_carry;
    run("R13", 4'h3, 32'hFFFF_FFFF, 32'h7FFF_FFFF);
    run("R13", 4'h4, 32'h8000_0000, 32'h0000_0001);
    run("R13", 4'h6, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run("R6",  4'h1, 32'd9, 32'd9);
    run("R6",  4'h2, 32'd1, 32'd9);
  endtask

  initial begin
    rst_n = 1'b0;
    op_code = 4'h0; opnd_a = 32'h0; opnd_b = 32'h0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (result !== 32'h0 || carry_out || overflow || flag_gt || flag_eq || flag_lt) begin
      errors++;
      $display("FAIL R1 initial idle state: r=%h c=%b v=%b gel=%b%b%b exp all zero",
               result, carry_out, overflow, flag_gt, flag_eq, flag_lt);
    end
    t_idle_unused();
    t_add();
    t_sub();
    t_compare();
    t_slt();
    t_logic();
    t_shifts();
    t_move();
    t_quiet_carry();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired: got running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule